// File: doc/BRIEF.md
# DRBG command legality and reseed-interval gate

This block sits in front of a deterministic random bit generator's command engine. It keeps two pieces of state for each application instance: whether the instance is instantiated, and how many generate commands it has completed since its last instantiate or reseed. Instance 0 is the software instance. All higher indices are hardware instances.

A command arrives as a 3-bit code and an instance index under a valid/ready handshake. The block decides whether the command may run, updates the instance's state, and returns a one-cycle acknowledge carrying a status code. A rejected command leaves all instance state unchanged and the block keeps running. Three sticky recoverable-alert bits record illegal codes, out-of-sequence commands and reseed-interval violations, and software clears them by writing zeros. A hardware instance that exceeds the interval also raises its own exception interrupt line. Software sets the generate limit through a 32-bit interval register.

Top module: `drbg_cmd_gate`

## Requirements
- R1: After reset, `interval_o` is 0xFFFFFFFF, `alert_sts_o` is 0, `ack_o` and `exc_irq_o` are 0, `cmd_ready_o` is 1, and no instance is instantiated.
- R2: A cycle with `interval_we_i` high loads `interval_wdata_i` into the interval register, and `interval_o` shows the value from the next cycle.
- R3: `cmd_ready_o` is always 1. Each cycle with `cmd_valid_i` high is one accepted command. In the following cycle, and only then, `ack_o` is 1, `ack_inst_o` echoes the index and `ack_sts_o` carries the status.
- R4: Command codes are 1 instantiate, 2 reseed, 3 generate, 4 update and 5 uninstantiate. A command that is allowed returns status 0.
- R5: A command with code 2 to 5, sent to an instance that is not instantiated, returns status 3 and sets alert bit 14. This includes uninstantiate.
- R6: An instantiate sent to an instance that is already instantiated returns status 3, sets alert bit 14 and does not clear that instance's counter.
- R7: Codes 0, 6 and 7, or an index of `N_INST` or more, return status 1, set alert bit 13 and change no instance state.
- R8: A generate to an instantiated instance whose counter is greater than or equal to the interval returns status 5 and sets alert bit 15. The counter does not advance. Status 5 is returned for no other code.
- R9: The counter behaves as follows:
  - A successful generate adds one to the counter, and the counter saturates at all-ones.
  - A successful instantiate, reseed or uninstantiate clears the counter.
  - An update leaves the counter unchanged.
  - An uninstantiate also clears the instantiated flag.
- R10: A status-5 rejection for an instance index of 1 or more pulses `exc_irq_o[index]` in the same cycle as its acknowledge. Instance 0 never raises an interrupt.
- R11: `alert_sts_o` bits 13, 14 and 15 stay set until a cycle with `alert_we_i` high and a 0 in the same bit of `alert_wdata_i`. A hardware set in that same cycle wins. Writing a 1 leaves a bit unchanged, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted (always 1) |
| cmd_code_i | input | 3 | Command code |
| cmd_inst_i | input | INST_W | Target instance index |
| ack_o | output | 1 | Acknowledge pulse |
| ack_sts_o | output | 3 | Status of the acknowledged command |
| ack_inst_o | output | INST_W | Instance of the acknowledged command |
| exc_irq_o | output | N_INST | Per-instance exception interrupt pulse |
| interval_we_i | input | 1 | Interval register write strobe |
| interval_wdata_i | input | CNT_W | Interval write data |
| interval_o | output | CNT_W | Current interval value |
| alert_we_i | input | 1 | Alert status write strobe (write zero to clear) |
| alert_wdata_i | input | 16 | Alert status write data |
| alert_sts_o | output | 16 | Sticky alert status |

## Verification
The bench drives several command sequences with an interval of 2, against both hardware and software instances:
- Generates with the counter below the limit, equal to it, and after a reseed show that the comparison uses greater-or-equal and that a reseed clears the counter.
- An update placed between a violation and a reseed shows that update leaves the counter alone.
- An uninstantiate followed by a fresh instantiate shows the instance coming back with a clean counter.
- Each wrong-state command (a generate or uninstantiate before instantiate, and a double instantiate) is paired with its correct-state counterpart, which tells the sequence error apart from the interval error.
- Raising the interval after a violation shows that the rejected generate did not advance the counter.
- An interval of zero shows that the very first generate after instantiate is refused.

// File: rtl/drbg_gate_pkg.sv
package drbg_gate_pkg;
  localparam logic [2:0] CMD_INS = 3'd1;
  localparam logic [2:0] CMD_RES = 3'd2;
  localparam logic [2:0] CMD_GEN = 3'd3;
  localparam logic [2:0] CMD_UPD = 3'd4;
  localparam logic [2:0] CMD_UNI = 3'd5;

  localparam logic [2:0] STS_OK      = 3'd0;
  localparam logic [2:0] STS_BAD_CMD = 3'd1;
  localparam logic [2:0] STS_SEQ     = 3'd3;
  localparam logic [2:0] STS_RESEED  = 3'd5;

  localparam int unsigned ALERT_W       = 16;
  localparam int unsigned ALERT_BAD_BIT = 13;
  localparam int unsigned ALERT_SEQ_BIT = 14;
  localparam int unsigned ALERT_CNT_BIT = 15;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_INST,
    ACT_CLR_CNT,
    ACT_INC,
    ACT_UNINST
  } act_e;
endpackage

// File: rtl/drbg_inst_state.sv
module drbg_inst_state
  import drbg_gate_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  act_e             act_i,
  output logic             inst_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inst_o <= 1'b0;
      cnt_o  <= '0;
    end else if (sel_i) begin
      unique case (act_i)
        ACT_INST: begin
          inst_o <= 1'b1;
          cnt_o  <= '0;
        end
        ACT_CLR_CNT: cnt_o <= '0;
        ACT_INC: if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
        ACT_UNINST: begin
          inst_o <= 1'b0;
          cnt_o  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/drbg_cmd_decide.sv
module drbg_cmd_decide
  import drbg_gate_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [2:0]       code_i,
  input  logic             idx_ok_i,
  input  logic             inst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] interval_i,
  output act_e             act_o,
  output logic [2:0]       sts_o,
  output logic             bad_cmd_o,
  output logic             seq_err_o,
  output logic             cnt_err_o
);
  logic legal;
  assign legal = idx_ok_i && (code_i >= CMD_INS) && (code_i <= CMD_UNI);

  always_comb begin
    act_o     = ACT_NONE;
    sts_o     = STS_OK;
    bad_cmd_o = 1'b0;
    seq_err_o = 1'b0;
    cnt_err_o = 1'b0;
    if (!legal) begin
      sts_o     = STS_BAD_CMD;
      bad_cmd_o = 1'b1;
    end else if ((code_i == CMD_INS) == inst_i) begin
      // instantiate on a live instance, or anything else on an idle one
      sts_o     = STS_SEQ;
      seq_err_o = 1'b1;
    end else begin
      unique case (code_i)
        CMD_INS: act_o = ACT_INST;
        CMD_RES: act_o = ACT_CLR_CNT;
        CMD_UNI: act_o = ACT_UNINST;
        CMD_GEN: begin
          if (cnt_i >= interval_i) begin
            sts_o     = STS_RESEED;
            cnt_err_o = 1'b1;
          end else begin
            act_o = ACT_INC;
          end
        end
        default: act_o = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/drbg_alert_regs.sv
module drbg_alert_regs
  import drbg_gate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ALERT_W-1:0] set_i,
  input  logic               we_i,
  input  logic [ALERT_W-1:0] wdata_i,
  output logic [ALERT_W-1:0] q_o
);
  localparam logic [ALERT_W-1:0] IMPL_MASK =
    ALERT_W'((1 << ALERT_BAD_BIT) | (1 << ALERT_SEQ_BIT) | (1 << ALERT_CNT_BIT));

  logic [ALERT_W-1:0] keep;
  assign keep = we_i ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o & keep) | set_i) & IMPL_MASK;
  end
endmodule

// File: rtl/drbg_cmd_gate.sv
module drbg_cmd_gate
  import drbg_gate_pkg::*;
#(
  parameter int unsigned N_INST = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned INST_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [2:0]         cmd_code_i,
  input  logic [INST_W-1:0]  cmd_inst_i,
  output logic               ack_o,
  output logic [2:0]         ack_sts_o,
  output logic [INST_W-1:0]  ack_inst_o,
  output logic [N_INST-1:0]  exc_irq_o,
  input  logic               interval_we_i,
  input  logic [CNT_W-1:0]   interval_wdata_i,
  output logic [CNT_W-1:0]   interval_o,
  input  logic               alert_we_i,
  input  logic [ALERT_W-1:0] alert_wdata_i,
  output logic [ALERT_W-1:0] alert_sts_o
);
  localparam int unsigned IDX_SPAN = 1 << INST_W;

  logic              hs;
  logic              idx_ok;
  logic [N_INST-1:0] inst_q;
  logic [CNT_W-1:0]  cnt_q [N_INST];
  logic              cur_inst;
  logic [CNT_W-1:0]  cur_cnt;
  act_e              act;
  logic [2:0]        sts;
  logic              bad_cmd, seq_err, cnt_err;
  logic [ALERT_W-1:0] alert_set;

  assign cmd_ready_o = 1'b1;
  assign hs          = cmd_valid_i & cmd_ready_o;
  assign idx_ok      = (IDX_SPAN <= N_INST) || (32'(cmd_inst_i) < N_INST);

  always_comb begin
    cur_inst = 1'b0;
    cur_cnt  = '0;
    for (int i = 0; i < N_INST; i++) begin
      if (32'(cmd_inst_i) == i) begin
        cur_inst = inst_q[i];
        cur_cnt  = cnt_q[i];
      end
    end
  end

  drbg_cmd_decide #(.CNT_W(CNT_W)) u_decide (
    .code_i     (cmd_code_i),
    .idx_ok_i   (idx_ok),
    .inst_i     (cur_inst),
    .cnt_i      (cur_cnt),
    .interval_i (interval_o),
    .act_o      (act),
    .sts_o      (sts),
    .bad_cmd_o  (bad_cmd),
    .seq_err_o  (seq_err),
    .cnt_err_o  (cnt_err)
  );

  for (genvar g = 0; g < N_INST; g++) begin : g_inst
    logic sel;
    assign sel = hs && (32'(cmd_inst_i) == g);

    drbg_inst_state #(.CNT_W(CNT_W)) u_state (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel),
      .act_i  (act),
      .inst_o (inst_q[g]),
      .cnt_o  (cnt_q[g])
    );

    // instance 0 is the software instance and never interrupts
    if (g == 0) begin : g_sw
      assign exc_irq_o[g] = 1'b0;
    end else begin : g_hw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) exc_irq_o[g] <= 1'b0;
        else         exc_irq_o[g] <= sel && cnt_err;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      ack_sts_o  <= STS_OK;
      ack_inst_o <= '0;
      interval_o <= '1;
    end else begin
      ack_o <= hs;
      if (hs) begin
        ack_sts_o  <= sts;
        ack_inst_o <= cmd_inst_i;
      end
      if (interval_we_i) interval_o <= interval_wdata_i;
    end
  end

  always_comb begin
    alert_set                = '0;
    alert_set[ALERT_BAD_BIT] = hs & bad_cmd;
    alert_set[ALERT_SEQ_BIT] = hs & seq_err;
    alert_set[ALERT_CNT_BIT] = hs & cnt_err;
  end

  drbg_alert_regs u_alerts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (alert_set),
    .we_i    (alert_we_i),
    .wdata_i (alert_wdata_i),
    .q_o     (alert_sts_o)
  );
endmodule

// File: rtl/drbg_cmd_gate_chk.sv
module drbg_cmd_gate_chk
  import drbg_gate_pkg::*;
#(
  parameter int unsigned N_INST = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned INST_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic [2:0]         cmd_code_i,
  input logic [INST_W-1:0]  cmd_inst_i,
  input logic               ack_o,
  input logic [2:0]         ack_sts_o,
  input logic [INST_W-1:0]  ack_inst_o,
  input logic [N_INST-1:0]  exc_irq_o,
  input logic               interval_we_i,
  input logic [CNT_W-1:0]   interval_wdata_i,
  input logic [CNT_W-1:0]   interval_o,
  input logic               alert_we_i,
  input logic [ALERT_W-1:0] alert_wdata_i,
  input logic [ALERT_W-1:0] alert_sts_o
);
  a_r3_ack_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (ack_o && ack_inst_o == $past(cmd_inst_i)));

  a_r3_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !ack_o);

  a_r8_code5_gen_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_code_i != CMD_GEN) |=> ack_sts_o != STS_RESEED);

  a_r8_code5_sets_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_sts_o == STS_RESEED) |-> alert_sts_o[ALERT_CNT_BIT]);

  a_r10_irq_with_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exc_irq_o) |-> (ack_o && ack_sts_o == STS_RESEED && $onehot0(exc_irq_o)));

  a_r10_sw_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_irq_o[0]);

  a_r11_bad_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_sts_o[ALERT_BAD_BIT] && !(alert_we_i && !alert_wdata_i[ALERT_BAD_BIT]))
      |=> alert_sts_o[ALERT_BAD_BIT]);

  a_r11_seq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_sts_o[ALERT_SEQ_BIT] && !(alert_we_i && !alert_wdata_i[ALERT_SEQ_BIT]))
      |=> alert_sts_o[ALERT_SEQ_BIT]);

  a_r11_cnt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_sts_o[ALERT_CNT_BIT] && !(alert_we_i && !alert_wdata_i[ALERT_CNT_BIT]))
      |=> alert_sts_o[ALERT_CNT_BIT]);

  a_r2_interval_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interval_we_i |=> $stable(interval_o));
endmodule

bind drbg_cmd_gate drbg_cmd_gate_chk #(
  .N_INST(N_INST), .CNT_W(CNT_W), .INST_W(INST_W)
) u_chk (.*);

// File: tb/drbg_cmd_gate_tb.sv
`timescale 1ns/1ps
module drbg_cmd_gate_tb;
  localparam int N_INST = 4;
  localparam int CNT_W  = 32;
  localparam int INST_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_code = '0;
  logic [INST_W-1:0] cmd_inst = '0;
  logic ack;
  logic [2:0] ack_sts;
  logic [INST_W-1:0] ack_inst;
  logic [N_INST-1:0] exc_irq;
  logic interval_we = 1'b0;
  logic [CNT_W-1:0] interval_wdata = '0;
  logic [CNT_W-1:0] interval;
  logic alert_we = 1'b0;
  logic [15:0] alert_wdata = '0;
  logic [15:0] alert_sts;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  drbg_cmd_gate #(.N_INST(N_INST), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_code_i(cmd_code), .cmd_inst_i(cmd_inst),
    .ack_o(ack), .ack_sts_o(ack_sts), .ack_inst_o(ack_inst),
    .exc_irq_o(exc_irq),
    .interval_we_i(interval_we), .interval_wdata_i(interval_wdata),
    .interval_o(interval),
    .alert_we_i(alert_we), .alert_wdata_i(alert_wdata),
    .alert_sts_o(alert_sts)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue one command, then sample the acknowledge one cycle later
  task automatic run_cmd(input logic [2:0] code, input logic [1:0] inst,
                         input logic [2:0] exp_sts, input logic [3:0] exp_irq,
                         input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_inst = inst;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({31'd0, ack}, 32'd1, {req, " ack"});
    check({30'd0, ack_inst}, {30'd0, inst}, {req, " ack_inst"});
    check({29'd0, ack_sts}, {29'd0, exp_sts}, {req, " status"});
    check({28'd0, exc_irq}, {28'd0, exp_irq}, {req, " irq"});
  endtask

  task automatic set_interval(input logic [31:0] v);
    @(negedge clk);
    interval_we = 1'b1; interval_wdata = v;
    @(negedge clk);
    interval_we = 1'b0;
  endtask

  task automatic write_alert(input logic [15:0] v);
    @(negedge clk);
    alert_we = 1'b1; alert_wdata = v;
    @(negedge clk);
    alert_we = 1'b0;
  endtask

  // {code, inst, status, irq}; interval is 2
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    {3'd3, 2'd1, 3'd3, 4'h0},  // R5 generate before instantiate
    {3'd5, 2'd1, 3'd3, 4'h0},  // R5 uninstantiate before instantiate
    {3'd1, 2'd1, 3'd0, 4'h0},  // R4
    {3'd1, 2'd1, 3'd3, 4'h0},  // R6 double instantiate
    {3'd3, 2'd1, 3'd0, 4'h0},  // R9
    {3'd3, 2'd1, 3'd0, 4'h0},  // R9
    {3'd3, 2'd1, 3'd5, 4'h2},  // R8 R10 limit reached
    {3'd4, 2'd1, 3'd0, 4'h0},  // R9 update keeps count
    {3'd3, 2'd1, 3'd5, 4'h2},  // R9 still at limit
    {3'd2, 2'd1, 3'd0, 4'h0},  // R9 reseed clears
    {3'd3, 2'd1, 3'd0, 4'h0},
    {3'd0, 2'd1, 3'd1, 4'h0},  // R7 code 0
    {3'd7, 2'd2, 3'd1, 4'h0},  // R7 code 7
    {3'd6, 2'd1, 3'd1, 4'h0},  // R7 code 6
    {3'd1, 2'd0, 3'd0, 4'h0},
    {3'd3, 2'd0, 3'd0, 4'h0},
    {3'd3, 2'd0, 3'd0, 4'h0},
    {3'd3, 2'd0, 3'd5, 4'h0},  // R10 software instance: no irq
    {3'd5, 2'd1, 3'd0, 4'h0},  // R9 uninstantiate
    {3'd3, 2'd1, 3'd3, 4'h0},  // R9 flag cleared
    {3'd1, 2'd1, 3'd0, 4'h0},
    {3'd3, 2'd1, 3'd0, 4'h0}   // R9 fresh counter
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(interval, 32'hFFFF_FFFF, "R1 interval");
    check({16'd0, alert_sts}, 32'd0, "R1 alerts");
    check({31'd0, ack}, 32'd0, "R1 ack");
    check({28'd0, exc_irq}, 32'd0, "R1 irq");
    check({31'd0, cmd_ready}, 32'd1, "R1 ready");

    set_interval(32'd2);
    check(interval, 32'd2, "R2 interval readback");
    @(negedge clk);
    check({31'd0, ack}, 32'd0, "R3 idle ack");

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][11:9], VEC[i][8:7], VEC[i][6:4], VEC[i][3:0],
              $sformatf("R4 vec%0d", i));
    end
    check({16'd0, alert_sts}, 32'h0000_E000, "R11 all alerts set");

    // R11 clearing only bit 14, then a write of ones changes nothing
    write_alert(16'hBFFF);
    check({16'd0, alert_sts}, 32'h0000_A000, "R11 clear bit14");
    write_alert(16'hFFFF);
    check({16'd0, alert_sts}, 32'h0000_A000, "R11 ones keep");
    write_alert(16'h0000);
    check({16'd0, alert_sts}, 32'h0000_0000, "R11 clear all");

    // R8 rejected generate did not advance instance 0 counter (still 2)
    set_interval(32'd3);
    run_cmd(3'd3, 2'd0, 3'd0, 4'h0, "R8 count not advanced");
    run_cmd(3'd3, 2'd0, 3'd5, 4'h0, "R8 new limit");
    check({16'd0, alert_sts}, 32'h0000_8000, "R8 alert bit15 only");

    // R8 interval zero refuses the first generate
    set_interval(32'd0);
    run_cmd(3'd1, 2'd3, 3'd0, 4'h0, "R8 inst3 instantiate");
    run_cmd(3'd3, 2'd3, 3'd5, 4'h8, "R8 R10 zero interval");

    // R11 set wins over a same-cycle clear
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd7; cmd_inst = 2'd0;
    alert_we = 1'b1; alert_wdata = 16'h0000;
    @(negedge clk);
    cmd_valid = 1'b0; alert_we = 1'b0;
    check({16'd0, alert_sts}, 32'h0000_2000, "R11 set wins");
    check({29'd0, ack_sts}, 32'd1, "R7 status");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule